// File: doc/BRIEF.md
# Maskable Interrupt Status Aggregator

This block gathers ten single-cycle event pulses from a storage-card host controller into one sticky status word and drives a single interrupt line. Each pulse sets its own status bit, which stays set until the host writes a 1 to that bit position. A separate enable word decides which set bits reach the interrupt line, and the line is driven from a flop.

The host reaches the block through a plain 32-bit register port: an address, a write strobe with write data, and combinational read data. Three words are mapped: status at offset 0x00, enable at offset 0x04 and a data-status word at offset 0x08. The level of the card's own interrupt request is reported in the data-status word, apart from the sticky status bits.

Top module: `irq_aggregator`

## Requirements
- R1: After synchronous reset the status word, the enable word and `irq_o` are all zero.
- R2: A one-cycle pulse on `evt_pulse[i]` sets status bit i at the next clock edge, and the bit stays set after the pulse ends until it is cleared. Bit map: 0 data done, 1 data timeout, 2 read CRC error, 3 write CRC error, 4 programming error, 5 card interrupt, 6 command sent, 7 command timeout, 8 response CRC error, 9 busy end.
- R3: A write to the status word (offset 0x00) clears every status bit whose written bit is 1; writing 0x3FF clears all ten bits.
- R4: A write to the status word neither sets a bit nor clears a bit whose written bit is 0.
- R5: When a pulse on source i and a clearing write to bit i occur in the same cycle, bit i ends up set.
- R6: The enable word (offset 0x04) stores bits 9:0 of the written value, using the same bit positions as the status word; it reads back those bits.
- R7: `irq_o` is 1 exactly one cycle after a cycle in which some status bit and the matching enable bit are both 1, and 0 otherwise.
- R8: A set status bit whose enable bit is 0 does not raise `irq_o`, but still reads as 1 in the status word.
- R9: Bit 8 of the data-status word (offset 0x08) reads the current level of `card_irq_lvl`, independent of the status word; every other bit of that word reads 0.
- R10: Bits 31:10 of the status and enable words read as 0, and writes to any unmapped offset or to the data-status word change no state; unmapped offsets read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_pulse | input | 10 | One single-cycle event pulse per source |
| card_irq_lvl | input | 1 | Level of the card's interrupt request |
| reg_addr | input | 8 | Byte offset of the register access |
| reg_we | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| irq_o | output | 1 | Registered interrupt line |

## Verification
Single pulses on the lowest, a middle and the highest source check that each lands on its own bit and stays there, while a burst on several sources at once followed by a partial clear mask tells a true write-one-to-clear apart from a plain overwrite. A pulse placed in the same cycle as the clear of its own bit separates event priority from clear priority. Enable patterns that cover, miss and partly overlap the set status bits distinguish the masked OR from an unmasked one, and the sampling cycle shows the one-cycle register stage on the line. Toggling the card level while status holds other values shows that the data-status bit is wired to the level and not to the sticky bit.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;

    localparam int NUM_SRC  = 10;
    localparam int DATA_W   = 32;
    localparam int ADDR_W   = 8;

    localparam logic [ADDR_W-1:0] OFS_STATUS = 8'h00;
    localparam logic [ADDR_W-1:0] OFS_ENABLE = 8'h04;
    localparam logic [ADDR_W-1:0] OFS_DSTAT  = 8'h08;

    localparam int CARD_LVL_BIT = 8;

    typedef enum logic [3:0] {
        SRC_DATA_DONE  = 4'd0,
        SRC_DATA_TMO   = 4'd1,
        SRC_RD_CRC     = 4'd2,
        SRC_WR_CRC     = 4'd3,
        SRC_PROG_ERR   = 4'd4,
        SRC_CARD_IRQ   = 4'd5,
        SRC_CMD_SENT   = 4'd6,
        SRC_CMD_TMO    = 4'd7,
        SRC_RESP_CRC   = 4'd8,
        SRC_BUSY_END   = 4'd9
    } src_e;

    typedef enum logic [1:0] {
        SEL_NONE   = 2'd0,
        SEL_STATUS = 2'd1,
        SEL_ENABLE = 2'd2,
        SEL_DSTAT  = 2'd3
    } reg_sel_e;

    function automatic reg_sel_e decode_addr(logic [ADDR_W-1:0] a);
        case (a)
            OFS_STATUS: return SEL_STATUS;
            OFS_ENABLE: return SEL_ENABLE;
            OFS_DSTAT:  return SEL_DSTAT;
            default:    return SEL_NONE;
        endcase
    endfunction

endpackage

// File: rtl/irq_status_bank.sv
module irq_status_bank
    import irq_agg_pkg::*;
#(
    parameter int N = NUM_SRC
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] status_o
);

    for (genvar g = 0; g < N; g++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst)
                status_o[g] <= 1'b0;
            else if (set_i[g])
                status_o[g] <= 1'b1;
            else if (clr_i[g])
                status_o[g] <= 1'b0;
        end

        // R2 / R5: an event always leaves its bit set, even against a clear
        p_event_sets_r5: assert property (@(posedge clk) disable iff (rst)
            set_i[g] |=> status_o[g]);

        // R2: sticky without a clear
        p_sticky_r2: assert property (@(posedge clk) disable iff (rst)
            (status_o[g] && !clr_i[g]) |=> status_o[g]);

        // R3: clear without event drops the bit
        p_clear_r3: assert property (@(posedge clk) disable iff (rst)
            (clr_i[g] && !set_i[g]) |=> !status_o[g]);

        // R4: no bit rises without its event
        p_no_spurious_r4: assert property (@(posedge clk) disable iff (rst)
            (!status_o[g] && !set_i[g]) |=> !status_o[g]);
    end

endmodule

// File: rtl/irq_reg_port.sv
module irq_reg_port
    import irq_agg_pkg::*;
#(
    parameter int N  = NUM_SRC,
    parameter int AW = ADDR_W,
    parameter int DW = DATA_W,
    parameter int LVL_BIT = CARD_LVL_BIT
) (
    input  logic [AW-1:0] addr_i,
    input  logic          we_i,
    input  logic [DW-1:0] wdata_i,
    input  logic [N-1:0]  status_i,
    input  logic [N-1:0]  enable_i,
    input  logic          card_lvl_i,
    output logic [N-1:0]  clr_mask_o,
    output logic          en_we_o,
    output logic [N-1:0]  en_wdata_o,
    output logic [DW-1:0] rdata_o
);

    reg_sel_e sel;

    always_comb begin
        sel        = decode_addr(addr_i);
        clr_mask_o = (we_i && sel == SEL_STATUS) ? wdata_i[N-1:0] : '0;
        en_we_o    = we_i && (sel == SEL_ENABLE);
        en_wdata_o = wdata_i[N-1:0];
        rdata_o    = '0;
        case (sel)
            SEL_STATUS: rdata_o[N-1:0] = status_i;
            SEL_ENABLE: rdata_o[N-1:0] = enable_i;
            SEL_DSTAT:  rdata_o[LVL_BIT] = card_lvl_i;
            default:    rdata_o = '0;
        endcase
    end

endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
    import irq_agg_pkg::*;
#(
    parameter int N  = NUM_SRC,
    parameter int AW = ADDR_W,
    parameter int DW = DATA_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [N-1:0]  evt_pulse,
    input  logic          card_irq_lvl,
    input  logic [AW-1:0] reg_addr,
    input  logic          reg_we,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] reg_rdata,
    output logic          irq_o
);

    logic [N-1:0] status;
    logic [N-1:0] enable_q;
    logic [N-1:0] clr_mask;
    logic         en_we;
    logic [N-1:0] en_wdata;

    irq_status_bank #(.N(N)) u_bank (
        .clk      (clk),
        .rst      (rst),
        .set_i    (evt_pulse),
        .clr_i    (clr_mask),
        .status_o (status)
    );

    irq_reg_port #(.N(N), .AW(AW), .DW(DW)) u_port (
        .addr_i     (reg_addr),
        .we_i       (reg_we),
        .wdata_i    (reg_wdata),
        .status_i   (status),
        .enable_i   (enable_q),
        .card_lvl_i (card_irq_lvl),
        .clr_mask_o (clr_mask),
        .en_we_o    (en_we),
        .en_wdata_o (en_wdata),
        .rdata_o    (reg_rdata)
    );

    always_ff @(posedge clk) begin
        if (rst)
            enable_q <= '0;
        else if (en_we)
            enable_q <= en_wdata;
    end

    always_ff @(posedge clk) begin
        if (rst)
            irq_o <= 1'b0;
        else
            irq_o <= |(status & enable_q);
    end

    // R1: state is zero in the cycle after reset
    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> (status == '0 && enable_q == '0 && !irq_o));

    // R7: no pending enabled bit means a quiet line next cycle
    p_quiet_line_r7: assert property (@(posedge clk) disable iff (rst)
        ((status & enable_q) == '0) |=> !irq_o);

    // R7: a pending enabled bit raises the line next cycle
    p_raise_line_r7: assert property (@(posedge clk) disable iff (rst)
        ((status & enable_q) != '0) |=> irq_o);

    // R6: enable word only moves on an enable write
    p_enable_hold_r6: assert property (@(posedge clk) disable iff (rst)
        !en_we |=> $stable(enable_q));

    // R10: upper read bits stay zero
    p_upper_zero_r10: assert property (@(posedge clk) disable iff (rst)
        reg_rdata[DW-1:N] == '0);

endmodule

// File: tb/irq_aggregator_test.sv
module irq_aggregator_test;

    logic        clk = 1'b0;
    logic        rst;
    logic [9:0]  evt_pulse;
    logic        card_irq_lvl;
    logic [7:0]  reg_addr;
    logic        reg_we;
    logic [31:0] reg_wdata;
    logic [31:0] reg_rdata;
    logic        irq_o;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    irq_aggregator uut (
        .clk(clk), .rst(rst), .evt_pulse(evt_pulse), .card_irq_lvl(card_irq_lvl),
        .reg_addr(reg_addr), .reg_we(reg_we), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq_o(irq_o)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_we = 1'b1;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic pulse(input logic [9:0] m);
        @(negedge clk);
        evt_pulse = m;
        @(negedge clk);
        evt_pulse = '0;
    endtask

    task automatic clear_all();
        wr(8'h04, 32'h0);
        wr(8'h00, 32'h3FF);
        @(negedge clk);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        rd(8'h00, d); check("R1 status", d, 32'h0);
        rd(8'h04, d); check("R1 enable", d, 32'h0);
        check("R1 irq", {31'b0, irq_o}, 32'h0);
    endtask

    task automatic t_sticky();
        logic [31:0] d;
        pulse(10'h001);
        rd(8'h00, d); check("R2 bit0 sticky", d, 32'h001);
        pulse(10'h200);
        pulse(10'h020);
        repeat (3) @(negedge clk);
        rd(8'h00, d); check("R2 bits 9,5,0 sticky", d, 32'h221);
        clear_all();
    endtask

    task automatic t_w1c();
        logic [31:0] d;
        pulse(10'h0F5);
        wr(8'h00, 32'h0000_0031);
        rd(8'h00, d); check("R3 partial clear", d, 32'h0C4);
        wr(8'h00, 32'h0);
        rd(8'h00, d); check("R4 zero write keeps", d, 32'h0C4);
        wr(8'h00, 32'hFFFF_FC00 | 32'h300);
        rd(8'h00, d); check("R4 clear of unset bits sets nothing", d, 32'h0C4);
        wr(8'h00, 32'h3FF);
        rd(8'h00, d); check("R3 0x3FF clears all", d, 32'h0);
    endtask

    task automatic t_collision();
        logic [31:0] d;
        pulse(10'h00C);
        @(negedge clk);
        reg_addr = 8'h00; reg_wdata = 32'h00C; reg_we = 1'b1; evt_pulse = 10'h004;
        @(negedge clk);
        reg_we = 1'b0; evt_pulse = '0;
        rd(8'h00, d); check("R5 event wins over clear", d, 32'h004);
        clear_all();
    endtask

    task automatic t_enable();
        logic [31:0] d;
        wr(8'h04, 32'hFFFF_F2A5);
        rd(8'h04, d); check("R6 enable readback", d, 32'h2A5);
        check("R10 upper enable bits zero", d & 32'hFFFF_FC00, 32'h0);
        wr(8'h04, 32'h0);
    endtask

    task automatic t_irq();
        logic [31:0] d;
        wr(8'h04, 32'h180);
        @(negedge clk);
        evt_pulse = 10'h080;
        @(negedge clk);
        evt_pulse = '0;
        check("R7 irq one cycle late (still 0)", {31'b0, irq_o}, 32'h0);
        @(negedge clk);
        check("R7 irq raised", {31'b0, irq_o}, 32'h1);
        @(negedge clk);
        reg_addr = 8'h00; reg_wdata = 32'h080; reg_we = 1'b1;
        @(negedge clk);
        reg_we = 1'b0;
        check("R7 irq held one cycle after clear", {31'b0, irq_o}, 32'h1);
        @(negedge clk);
        check("R7 irq dropped", {31'b0, irq_o}, 32'h0);
        pulse(10'h03F);
        @(negedge clk);
        check("R8 masked bits keep irq low", {31'b0, irq_o}, 32'h0);
        rd(8'h00, d); check("R8 masked bits still set", d, 32'h03F);
        wr(8'h04, 32'h020);
        @(negedge clk);
        check("R7 enabling a set bit raises irq", {31'b0, irq_o}, 32'h1);
        clear_all();
        check("R7 irq low after clear_all", {31'b0, irq_o}, 32'h0);
    endtask

    task automatic t_card_lvl();
        logic [31:0] d;
        card_irq_lvl = 1'b1;
        rd(8'h08, d); check("R9 level high", d, 32'h100);
        rd(8'h00, d); check("R9 status untouched by level", d, 32'h0);
        pulse(10'h020);
        card_irq_lvl = 1'b0;
        rd(8'h08, d); check("R9 level low with bit5 set", d, 32'h0);
        clear_all();
    endtask

    task automatic t_unmapped();
        logic [31:0] d;
        pulse(10'h3FF);
        wr(8'h0C, 32'hFFFF_FFFF);
        wr(8'h08, 32'hFFFF_FFFF);
        rd(8'h00, d); check("R10 unmapped write ignored (status)", d, 32'h3FF);
        rd(8'h04, d); check("R10 unmapped write ignored (enable)", d, 32'h0);
        rd(8'h0C, d); check("R10 unmapped reads zero", d, 32'h0);
        rd(8'h00, d); check("R10 upper status bits zero", d & 32'hFFFF_FC00, 32'h0);
        clear_all();
    endtask

    initial begin
        #1_000_000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst = 1'b1; evt_pulse = '0; card_irq_lvl = 1'b0;
        reg_addr = '0; reg_we = 1'b0; reg_wdata = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_sticky();
        t_w1c();
        t_collision();
        t_enable();
        t_irq();
        t_card_lvl();
        t_unmapped();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule